// File: doc/BRIEF.md
# Carry-Policy Arithmetic-Logic Unit

This block is a 32-bit arithmetic-logic unit whose 4-bit operation code chooses three things at once: the core function (add, OR, AND or XOR), where the adder's carry-in comes from, and what happens to a stored carry flag once the operation completes. Subtraction is an add with the right operand inverted. The carry-in can be constant zero, constant one, the stored flag, or the flag's complement. The flag update can keep the old value, clear it, load the carry-out, or load the inverted carry-out. Chaining subtractions with a borrow therefore works without any extra opcodes.

The result and the overflow indication are combinational from the operands, the opcode and the current flag. The flag is the only state in the block. It changes on a rising clock edge only when the valid strobe is high. Reset clears it.

Opcode map (value: behaviour): 0 signed add, 1 signed subtract, 2 unsigned add, 3 unsigned subtract, 4 wrapping add, 5 wrapping subtract, 6 plain add, 7 plain subtract, 8 second wrapping add, 9 bounds check, 10 OR, 11 AND, 12 XOR, 13 auxiliary (same as OR), 14 and 15 reserved.

Top module: `alu_cp_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `carry_flag` becomes 0.
- R2: For add opcodes the result is A + B + cin modulo 2^32. The carry-in cin is the stored flag for opcodes 0 and 2, and 0 for opcodes 4, 6 and 8.
- R3: For subtract opcodes the result is A + ~B + cin modulo 2^32. The carry-in cin is the inverted stored flag for opcodes 1 and 3, and 1 for opcodes 5, 7 and 9.
- R4: A valid operation with opcode 0, 1, 6 or 7 clears the flag at the clock edge.
- R5: A valid opcode 2 loads the adder carry-out (bit 32 of the sum) into the flag. A valid opcode 3 loads the inverted carry-out.
- R6: A valid operation with opcode 4, 5, 8, 9, 10, 11, 12 or 13 leaves the flag unchanged.
- R7: Opcodes 10 and 13 give A OR B, opcode 11 gives A AND B, and opcode 12 gives A XOR B.
- R8: Opcodes 14 and 15 give a zero result and no overflow, and a valid operation with either one leaves the flag unchanged.
- R9: `overflow` is high only for opcodes 0 and 1. It is high when bit 31 of A equals bit 31 of the adder's second operand (B after any inversion) and bit 31 of the result differs from it.
- R10: When `op_valid` is low the flag keeps its value, whatever the opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe: the flag update of this cycle's operation takes effect |
| opcode | input | 4 | Operation code |
| opnd_a | input | 32 | Left operand |
| opnd_b | input | 32 | Right operand |
| result | output | 32 | Combinational result |
| carry_flag | output | 1 | Stored carry flag |
| overflow | output | 1 | Signed overflow of the current operation |

## Verification
On every cycle, the assertions check the flag policy of each opcode group: clear, load carry, keep, and hold while the strobe is low. They also check that reserved codes and non-signed codes never raise overflow, and that the OR result is right. Only the bench scenarios show that carry-in selection from the stored flag is right across chained operations. The same is true of exact subtract results with a borrow, of reset taking the flag from 1 back to 0, and of the overflow boundaries at the most positive and most negative values.

// File: rtl/alu_cp_pkg.sv
package alu_cp_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OPC_W  = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_SGN_ADD   = 4'd0,
        OPC_SGN_SUB   = 4'd1,
        OPC_UNS_ADD   = 4'd2,
        OPC_UNS_SUB   = 4'd3,
        OPC_WRAP_ADD  = 4'd4,
        OPC_WRAP_SUB  = 4'd5,
        OPC_PLAIN_ADD = 4'd6,
        OPC_PLAIN_SUB = 4'd7,
        OPC_WRAP_ADD2 = 4'd8,
        OPC_BOUND     = 4'd9,
        OPC_OR        = 4'd10,
        OPC_AND       = 4'd11,
        OPC_XOR       = 4'd12,
        OPC_AUX       = 4'd13,
        OPC_RSV0      = 4'd14,
        OPC_RSV1      = 4'd15
    } opc_e;

    typedef enum logic [1:0] {FN_ADD, FN_OR, FN_AND, FN_XOR} fn_e;
    typedef enum logic [1:0] {CIN_FLAG, CIN_NFLAG, CIN_ZERO, CIN_ONE} cin_e;
    typedef enum logic [1:0] {CY_KEEP, CY_CLEAR, CY_COUT, CY_NCOUT} cy_e;

    typedef struct packed {
        fn_e  fn;
        cin_e cin;
        cy_e  cy;
        logic inv_b;
        logic sgn_ovf;
        logic legal;
    } ctrl_t;

    function automatic ctrl_t mk_ctrl(fn_e fn, cin_e cin, cy_e cy, logic inv_b, logic sgn_ovf);
        ctrl_t c;
        c.fn      = fn;
        c.cin     = cin;
        c.cy      = cy;
        c.inv_b   = inv_b;
        c.sgn_ovf = sgn_ovf;
        c.legal   = 1'b1;
        return c;
    endfunction

    function automatic ctrl_t decode_opc(logic [OPC_W-1:0] code);
        ctrl_t c;
        case (opc_e'(code))
            OPC_SGN_ADD:   c = mk_ctrl(FN_ADD, CIN_FLAG,  CY_CLEAR, 1'b0, 1'b1);
            OPC_SGN_SUB:   c = mk_ctrl(FN_ADD, CIN_NFLAG, CY_CLEAR, 1'b1, 1'b1);
            OPC_UNS_ADD:   c = mk_ctrl(FN_ADD, CIN_FLAG,  CY_COUT,  1'b0, 1'b0);
            OPC_UNS_SUB:   c = mk_ctrl(FN_ADD, CIN_NFLAG, CY_NCOUT, 1'b1, 1'b0);
            OPC_WRAP_ADD,
            OPC_WRAP_ADD2: c = mk_ctrl(FN_ADD, CIN_ZERO,  CY_KEEP,  1'b0, 1'b0);
            OPC_WRAP_SUB,
            OPC_BOUND:     c = mk_ctrl(FN_ADD, CIN_ONE,   CY_KEEP,  1'b1, 1'b0);
            OPC_PLAIN_ADD: c = mk_ctrl(FN_ADD, CIN_ZERO,  CY_CLEAR, 1'b0, 1'b0);
            OPC_PLAIN_SUB: c = mk_ctrl(FN_ADD, CIN_ONE,   CY_CLEAR, 1'b1, 1'b0);
            OPC_OR,
            OPC_AUX:       c = mk_ctrl(FN_OR,  CIN_ZERO,  CY_KEEP,  1'b0, 1'b0);
            OPC_AND:       c = mk_ctrl(FN_AND, CIN_ZERO,  CY_KEEP,  1'b0, 1'b0);
            OPC_XOR:       c = mk_ctrl(FN_XOR, CIN_ZERO,  CY_KEEP,  1'b0, 1'b0);
            default: begin
                c       = mk_ctrl(FN_OR, CIN_ZERO, CY_KEEP, 1'b0, 1'b0);
                c.legal = 1'b0;
            end
        endcase
        return c;
    endfunction

    function automatic logic pick_cin(cin_e sel, logic flag);
        case (sel)
            CIN_FLAG:  return flag;
            CIN_NFLAG: return ~flag;
            CIN_ONE:   return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/alu_cp_decode.sv
module alu_cp_decode
    import alu_cp_pkg::*;
#(
    parameter int unsigned CODE_W = OPC_W
) (
    input  logic [CODE_W-1:0] code,
    output ctrl_t             ctrl
);
    always_comb begin
        ctrl = decode_opc(code[OPC_W-1:0]);
    end
endmodule

// File: rtl/alu_cp_core.sv
module alu_cp_core
    import alu_cp_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  ctrl_t        ctrl,
    input  logic         flag,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         ovf
);
    localparam int unsigned SW = W + 1;

    logic [W-1:0]  b_eff;
    logic          cin;
    logic [SW-1:0] sum;
    logic [W-1:0]  logic_res;

    // Per-bit operand conditioning, one slice per bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign b_eff[i] = b[i] ^ ctrl.inv_b;
    end

    always_comb begin
        cin  = pick_cin(ctrl.cin, flag);
        sum  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
        cout = sum[W];
        case (ctrl.fn)
            FN_OR:   logic_res = a | b;
            FN_AND:  logic_res = a & b;
            FN_XOR:  logic_res = a ^ b;
            default: logic_res = sum[W-1:0];
        endcase
        res = ctrl.legal ? logic_res : '0;
        ovf = ctrl.legal && ctrl.sgn_ovf
              && (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_cp_flag.sv
module alu_cp_flag
    import alu_cp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  cy_e  policy,
    input  logic cout,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (upd) begin
            case (policy)
                CY_CLEAR: flag <= 1'b0;
                CY_COUT:  flag <= cout;
                CY_NCOUT: flag <= ~cout;
                default:  flag <= flag;
            endcase
        end
    end
endmodule

// File: rtl/alu_cp_top.sv
module alu_cp_top
    import alu_cp_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    output logic [W-1:0]     result,
    output logic             carry_flag,
    output logic             overflow
);
    ctrl_t ctrl;
    logic  cout;

    alu_cp_decode #(.CODE_W(OPC_W)) u_dec (
        .code (opcode),
        .ctrl (ctrl)
    );

    alu_cp_core #(.W(W)) u_core (
        .ctrl (ctrl),
        .flag (carry_flag),
        .a    (opnd_a),
        .b    (opnd_b),
        .res  (result),
        .cout (cout),
        .ovf  (overflow)
    );

    alu_cp_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .upd    (op_valid),
        .policy (ctrl.cy),
        .cout   (cout),
        .flag   (carry_flag)
    );
endmodule

// File: rtl/alu_cp_checker.sv
module alu_cp_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         op_valid,
    input logic [3:0]   opcode,
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic [W-1:0] result,
    input logic         carry_flag,
    input logic         overflow
);
    logic [W:0] uns_sum;
    logic       keep_grp;
    logic       clr_grp;

    assign uns_sum  = {1'b0, opnd_a} + {1'b0, opnd_b} + {{W{1'b0}}, carry_flag};
    assign clr_grp  = (opcode == 4'd0) || (opcode == 4'd1) || (opcode == 4'd6) || (opcode == 4'd7);
    assign keep_grp = (opcode == 4'd4) || (opcode == 4'd5) || (opcode >= 4'd8);

    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && clr_grp) |=> !carry_flag);

    p_load_cout_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opcode == 4'd2) |=> (carry_flag == $past(uns_sum[W])));

    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
        (op_valid && keep_grp) |=> $stable(carry_flag));

    p_or_result_r7: assert property (@(posedge clk) disable iff (rst)
        (opcode == 4'd10 || opcode == 4'd13) |-> (result == (opnd_a | opnd_b)));

    p_reserved_r8: assert property (@(posedge clk) disable iff (rst)
        (opcode >= 4'd14) |-> (result == '0 && !overflow));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (opcode > 4'd1) |-> !overflow);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(carry_flag));
endmodule

bind alu_cp_top alu_cp_checker #(.W(W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .opcode     (opcode),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .result     (result),
    .carry_flag (carry_flag),
    .overflow   (overflow)
);

// File: tb/test_alu_cp_top.sv
module test_alu_cp_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  opcode;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [31:0] result;
    logic        carry_flag;
    logic        overflow;

    int total = 0;
    int bad   = 0;
    logic exp_flag;
    bit   done = 0;

    always #2.5 clk = ~clk;

    alu_cp_top i_alu_cp_top (
        .clk(clk), .rst(rst), .op_valid(op_valid), .opcode(opcode),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .result(result),
        .carry_flag(carry_flag), .overflow(overflow)
    );

    // Returns {new_flag, overflow, result}.
    function automatic logic [33:0] model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                          logic f, logic v);
        logic [32:0] s;
        logic [31:0] r;
        logic nf, ov;
        logic [31:0] nb;
        nb = ~b;
        nf = f; ov = 1'b0; s = '0; r = '0;
        case (op)
            4'd0: begin s = {1'b0,a} + {1'b0,b} + 33'(f);
                ov = (a[31] == b[31]) && (s[31] != a[31]); nf = 1'b0; end
            4'd1: begin s = {1'b0,a} + {1'b0,nb} + 33'(!f);
                ov = (a[31] == nb[31]) && (s[31] != a[31]); nf = 1'b0; end
            4'd2: begin s = {1'b0,a} + {1'b0,b} + 33'(f); nf = s[32]; end
            4'd3: begin s = {1'b0,a} + {1'b0,nb} + 33'(!f); nf = !s[32]; end
            4'd4, 4'd8: s = {1'b0,a} + {1'b0,b};
            4'd5, 4'd9: s = {1'b0,a} + {1'b0,nb} + 33'd1;
            4'd6: begin s = {1'b0,a} + {1'b0,b}; nf = 1'b0; end
            4'd7: begin s = {1'b0,a} + {1'b0,nb} + 33'd1; nf = 1'b0; end
            default: s = '0;
        endcase
        case (op)
            4'd10, 4'd13: r = a | b;
            4'd11: r = a & b;
            4'd12: r = a ^ b;
            4'd14, 4'd15: r = '0;
            default: r = s[31:0];
        endcase
        if (!v) nf = f;
        return {nf, ov, r};
    endfunction

    function automatic string res_tag(logic [3:0] op);
        case (op)
            4'd0, 4'd2, 4'd4, 4'd6, 4'd8: return "R2";
            4'd1, 4'd3, 4'd5, 4'd7, 4'd9: return "R3";
            4'd14, 4'd15: return "R8";
            default: return "R7";
        endcase
    endfunction

    function automatic string flag_tag(logic [3:0] op, logic v);
        if (!v) return "R10";
        case (op)
            4'd0, 4'd1, 4'd6, 4'd7: return "R4";
            4'd2, 4'd3: return "R5";
            4'd14, 4'd15: return "R8";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(logic v, logic [3:0] op, logic [31:0] a, logic [31:0] b);
        logic [33:0] m;
        @(negedge clk);
        op_valid = v; opcode = op; opnd_a = a; opnd_b = b;
        #1;
        m = model(op, a, b, exp_flag, v);
        check(res_tag(op), "result", result, m[31:0]);
        check("R9", "overflow", {31'd0, overflow}, {31'd0, m[32]});
        @(posedge clk);
        #1;
        exp_flag = m[33];
        check(flag_tag(op, v), "carry_flag", {31'd0, carry_flag}, {31'd0, exp_flag});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; op_valid = 1'b0;
        @(posedge clk); #1;
        exp_flag = 1'b0;
        check("R1", "carry_flag after reset", {31'd0, carry_flag}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; op_valid = 1'b0; opcode = '0; opnd_a = '0; opnd_b = '0;
        exp_flag = 1'b0;
        repeat (2) @(posedge clk);
        do_reset();

        do_op(1, 4'd2, 32'hFFFF_FFFF, 32'h1);          // R5 carry out 1
        do_op(0, 4'd6, 32'h5, 32'h6);                   // R10 strobe low keeps 1
        do_op(1, 4'd0, 32'h1, 32'h1);                   // R2 uses flag: 3, R4 clears
        do_op(1, 4'd3, 32'h0, 32'h1);                   // R5 borrow sets flag
        do_op(1, 4'd1, 32'h10, 32'h3);                  // R3 with borrow: 0xC
        do_op(1, 4'd0, 32'h7FFF_FFFF, 32'h1);           // R9 positive overflow
        do_op(1, 4'd1, 32'h8000_0000, 32'h1);           // R9 negative overflow
        do_op(1, 4'd2, 32'h8000_0000, 32'h8000_0000);   // R5 set flag again
        do_op(1, 4'd14, 32'hDEAD_BEEF, 32'h1234_5678);  // R8 zero, flag kept
        do_op(1, 4'd15, 32'h7FFF_FFFF, 32'h7FFF_FFFF);  // R8
        do_op(1, 4'd9, 32'h5, 32'h9);                   // R6 bound check keeps
        do_op(1, 4'd13, 32'hF0F0_0000, 32'h0000_0F0F);  // R7 aux is OR
        do_op(1, 4'd8, 32'hFFFF_FFFF, 32'h1);           // R6 wrap add2
        do_reset();                                      // R1 from flag 1

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a, b;
            logic [3:0] op;
            logic v;
            a  = $urandom();
            b  = $urandom();
            op = 4'($urandom_range(15, 0));
            v  = ($urandom_range(7, 0) != 0);
            if (i % 5 == 0) b = 32'hFFFF_FFFF - a;
            if (i % 7 == 0) a = 32'h7FFF_FFFF;
            do_op(v, op, a, b);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule